// File: doc/BRIEF.md
# Flash command window register interface

This block is a memory-mapped register window through which a host drives a flash-style storage device. The host loads a command code, a two-part target address, an optional two-part word count and a data word into parameter registers. It then writes the value 1 to the launch register. The block decodes the command and either completes it at once (lock, unlock, lock query, information query, one-time-area read) or runs it through a busy timer of fixed length (word program, buffered program, block erase, one-time-area program). Program and erase runs can be paused and resumed.

A single status word reports progress and faults. Ready, available and the two paused flags are live views of the engine. The fault bits are sticky until the host reads the status word, and that read clears them. The array itself is not modelled. A per-block lock table, a fill counter for the program buffer, a one-time-area "already written" flag and a low-voltage input pin stand in for the real device.

Top module: `flash_cmd_window`

## Requirements
- R1: Reads return 0x0050, 0x0046, 0x004F and 0x0057 at offsets 0x00, 0x02, 0x04 and 0x06. Reads return the manufacturer and device ID parameters at 0x20 and 0x22, the buffer location parameter at 0x40 and the buffer depth in words at 0x42. Read data appears with `rd_valid` one cycle after `rd_en`.
- R2: Offsets 0x80 (command), 0x84 (data), 0x88/0x8A (address low/high) and 0x90/0x92 (count low/high) read back what was written. The full address is {high, low} and the full count is {high, low}. Writes to these registers while an operation is busy are ignored.
- R3: Only a write of 0x0001 to offset 0xC0 launches the held command. Any other value written there has no effect.
- R4: After reset the status word at 0xCC reads 0x8080: bit 15 is available and bit 7 is ready. Ready reads 0 from the cycle after a launch. It stays 0 for PROG_LAT cycles for program commands and ERASE_LAT cycles for block erase.
- R5: Command 0x61 locks and command 0x62 unlocks the block selected by address bits [BLK_LSB +: log2(NUM_BLOCKS)]. Command 0x65 writes that block's lock state (1 = locked) into the data register.
- R6: Word program (0x41), buffered program (0xE9) or erase (0x20) aimed at a locked block does not start. Instead it sets status bit 1.
- R7: Status bits 1, 3, 4, 5, 9:8 and 12 (mask 0x133A) are cleared on the edge that accepts a status read. A fault raised on that same edge is kept.
- R8: Word program (0x41) to an odd address does not start and sets status bits 9:8 to 11.
- R9: Each data register write while idle adds one word to the buffer fill, saturating at the buffer depth. Writing 0x0001 to 0xC4 empties the buffer; other values there are ignored. Buffered program with a count of 0 or a count above the fill sets status bit 4 and does not start. Otherwise it runs and empties the buffer.
- R10: Writing 0x0001 to 0xC8 during a run pauses it. While paused, ready reads 1 and status bit 6 (erase) or bit 2 (program) is set. Command 0xD0 resumes the run for the cycles it had left. Any other launch while paused is dropped.
- R11: A launch while busy, or a resume with nothing paused, is dropped and raises no fault.
- R12: If `vpp_low` is high on the last cycle of a run, status bit 3 is set, plus bit 5 when the run was an erase.
- R13: Command 0x97 loads OTP_STUB into the data register and 0x98 loads the buffer depth. The first one-time-area program (0xC0) runs for PROG_LAT cycles. Every later one sets status bit 12 and does not start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | AW | Byte offset within the window |
| wdata | input | 16 | Write data |
| vpp_low | input | 1 | Low programming voltage indication |
| rdata | output | 16 | Read data, valid with rd_valid |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |

## Verification
The bench times each run by reading the status word back-to-back from the cycle after launch. An engine that added a pipeline stage, or that restarted its timer when a second launch arrived during a run, gives the wrong busy count. A low-voltage fault raised on the very edge that also accepts a status read must survive into the next read; a design that let the read-clear win would lose it. Pausing midway and resuming must give exactly the remaining cycles; a design that reloaded the full latency gives too many. Locked, odd-address, empty-buffer and repeated one-time-area cases must leave ready high and show only their own fault code, and a write of 2 to the launch or buffer-clear register must change nothing.

// File: rtl/fcw_pkg.sv
package fcw_pkg;
    localparam int W = 16;

    // register window offsets
    localparam logic [7:0] OFS_Q0     = 8'h00;
    localparam logic [7:0] OFS_Q1     = 8'h02;
    localparam logic [7:0] OFS_Q2     = 8'h04;
    localparam logic [7:0] OFS_Q3     = 8'h06;
    localparam logic [7:0] OFS_MFR    = 8'h20;
    localparam logic [7:0] OFS_DEV    = 8'h22;
    localparam logic [7:0] OFS_BUFLOC = 8'h40;
    localparam logic [7:0] OFS_BUFSZ  = 8'h42;
    localparam logic [7:0] OFS_CMD    = 8'h80;
    localparam logic [7:0] OFS_DATA   = 8'h84;
    localparam logic [7:0] OFS_ALO    = 8'h88;
    localparam logic [7:0] OFS_AHI    = 8'h8A;
    localparam logic [7:0] OFS_CLO    = 8'h90;
    localparam logic [7:0] OFS_CHI    = 8'h92;
    localparam logic [7:0] OFS_GO     = 8'hC0;
    localparam logic [7:0] OFS_BCLR   = 8'hC4;
    localparam logic [7:0] OFS_PAUSE  = 8'hC8;
    localparam logic [7:0] OFS_STAT   = 8'hCC;

    // command codes
    localparam logic [W-1:0] OP_WPROG  = 16'h0041;
    localparam logic [W-1:0] OP_BPROG  = 16'h00E9;
    localparam logic [W-1:0] OP_ERASE  = 16'h0020;
    localparam logic [W-1:0] OP_LOCK   = 16'h0061;
    localparam logic [W-1:0] OP_UNLOCK = 16'h0062;
    localparam logic [W-1:0] OP_LKRD   = 16'h0065;
    localparam logic [W-1:0] OP_QUERY  = 16'h0098;
    localparam logic [W-1:0] OP_OTPRD  = 16'h0097;
    localparam logic [W-1:0] OP_OTPWR  = 16'h00C0;
    localparam logic [W-1:0] OP_RESUME = 16'h00D0;

    localparam logic [W-1:0] KEY_ONE   = 16'h0001;

    // status layout
    localparam int SB_PROT  = 1;
    localparam int SB_PSUSP = 2;
    localparam int SB_VLOW  = 3;
    localparam int SB_PERR  = 4;
    localparam int SB_EERR  = 5;
    localparam int SB_ESUSP = 6;
    localparam int SB_RDY   = 7;
    localparam int SB_RGN   = 8;
    localparam int SB_AOF   = 12;
    localparam int SB_AVAIL = 15;
    localparam logic [W-1:0] CLR_MASK = 16'h133A;

    typedef struct packed {
        logic       prot;
        logic       vlow;
        logic       perr;
        logic       eerr;
        logic       aof;
        logic [1:0] rgn;
    } fault_t;
endpackage

// File: rtl/fcw_params.sv
module fcw_params
    import fcw_pkg::*;
#(
    parameter int AW        = 8,
    parameter int BUF_WORDS = 8,
    localparam int FILL_W   = $clog2(BUF_WORDS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     addr,
    input  logic [W-1:0]      wdata,
    input  logic              busy,
    input  logic              res_we,
    input  logic [W-1:0]      res,
    input  logic              buf_use,
    output logic [W-1:0]      cmd_o,
    output logic [W-1:0]      data_o,
    output logic [W-1:0]      alo_o,
    output logic [W-1:0]      ahi_o,
    output logic [W-1:0]      clo_o,
    output logic [W-1:0]      chi_o,
    output logic [FILL_W-1:0] fill_o
);
    typedef struct packed {
        logic [W-1:0]      cmd;
        logic [W-1:0]      data;
        logic [W-1:0]      alo;
        logic [W-1:0]      ahi;
        logic [W-1:0]      clo;
        logic [W-1:0]      chi;
        logic [FILL_W-1:0] fill;
    } prm_t;

    prm_t st_d, st_q;
    logic wr_ok;

    always_comb begin
        st_d  = st_q;
        wr_ok = wr_en && !busy;
        if (wr_ok) begin
            case (addr)
                AW'(OFS_CMD): st_d.cmd = wdata;
                AW'(OFS_ALO): st_d.alo = wdata;
                AW'(OFS_AHI): st_d.ahi = wdata;
                AW'(OFS_CLO): st_d.clo = wdata;
                AW'(OFS_CHI): st_d.chi = wdata;
                AW'(OFS_DATA): begin
                    st_d.data = wdata;
                    if (st_q.fill != FILL_W'(BUF_WORDS))
                        st_d.fill = st_q.fill + 1'b1;
                end
                AW'(OFS_BCLR): if (wdata == KEY_ONE) st_d.fill = '0;
                default: ;
            endcase
        end
        if (buf_use) st_d.fill = '0;
        if (res_we)  st_d.data = res;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cmd_o  = st_q.cmd;
    assign data_o = st_q.data;
    assign alo_o  = st_q.alo;
    assign ahi_o  = st_q.ahi;
    assign clo_o  = st_q.clo;
    assign chi_o  = st_q.chi;
    assign fill_o = st_q.fill;

    // R2: parameter registers hold while a run is busy
    p_hold_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !res_we) |=> ($stable(alo_o) && $stable(ahi_o) && $stable(cmd_o)));

    // R9: buffer fill never exceeds its depth
    p_fill_cap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fill_o <= FILL_W'(BUF_WORDS));
endmodule

// File: rtl/fcw_engine.sv
module fcw_engine
    import fcw_pkg::*;
#(
    parameter int PROG_LAT   = 6,
    parameter int ERASE_LAT  = 10,
    parameter int NUM_BLOCKS = 8,
    parameter int BUF_WORDS  = 8,
    parameter logic [15:0] OTP_STUB = 16'h5A5A,
    localparam int BLK_W  = $clog2(NUM_BLOCKS),
    localparam int FILL_W = $clog2(BUF_WORDS + 1),
    localparam int MAXL   = (PROG_LAT > ERASE_LAT) ? PROG_LAT : ERASE_LAT,
    localparam int CNT_W  = $clog2(MAXL + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              pause,
    input  logic [W-1:0]      cmd,
    input  logic [BLK_W-1:0]  blk,
    input  logic              odd,
    input  logic [2*W-1:0]    count,
    input  logic [FILL_W-1:0] fill,
    input  logic              vpp_low,
    output logic              busy_o,
    output logic              susp_o,
    output logic              susp_erase_o,
    output fault_t            flt_o,
    output logic              res_we_o,
    output logic [W-1:0]      res_o,
    output logic              buf_use_o
);
    typedef struct packed {
        logic                  busy;
        logic                  susp;
        logic                  is_erase;
        logic [CNT_W-1:0]      cnt;
        logic [NUM_BLOCKS-1:0] locks;
        logic                  otp_done;
    } eng_t;

    eng_t st_d, st_q;
    logic locked, done, idle_go;

    always_comb begin
        st_d      = st_q;
        flt_o     = '0;
        res_we_o  = 1'b0;
        res_o     = '0;
        buf_use_o = 1'b0;
        locked    = st_q.locks[blk];
        done      = st_q.busy && (st_q.cnt == CNT_W'(1));
        idle_go   = go && !st_q.busy && !st_q.susp;

        if (st_q.busy) begin
            if (done) begin
                st_d.busy = 1'b0;
                st_d.cnt  = '0;
                if (vpp_low) begin
                    flt_o.vlow = 1'b1;
                    flt_o.eerr = st_q.is_erase;
                end
            end else if (pause) begin
                st_d.busy = 1'b0;
                st_d.susp = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end else if (go && st_q.susp) begin
            if (cmd == OP_RESUME) begin
                st_d.busy = 1'b1;
                st_d.susp = 1'b0;
            end
        end else if (idle_go) begin
            case (cmd)
                OP_WPROG: begin
                    if (locked)   flt_o.prot = 1'b1;
                    else if (odd) flt_o.rgn  = 2'b11;
                    else begin
                        st_d.busy = 1'b1; st_d.is_erase = 1'b0;
                        st_d.cnt  = CNT_W'(PROG_LAT);
                    end
                end
                OP_BPROG: begin
                    if (locked) flt_o.prot = 1'b1;
                    else if (count == '0 || count > (2*W)'(fill)) flt_o.perr = 1'b1;
                    else begin
                        st_d.busy = 1'b1; st_d.is_erase = 1'b0;
                        st_d.cnt  = CNT_W'(PROG_LAT);
                        buf_use_o = 1'b1;
                    end
                end
                OP_ERASE: begin
                    if (locked) flt_o.prot = 1'b1;
                    else begin
                        st_d.busy = 1'b1; st_d.is_erase = 1'b1;
                        st_d.cnt  = CNT_W'(ERASE_LAT);
                    end
                end
                OP_LOCK:   st_d.locks[blk] = 1'b1;
                OP_UNLOCK: st_d.locks[blk] = 1'b0;
                OP_LKRD: begin
                    res_we_o = 1'b1;
                    res_o    = W'(locked);
                end
                OP_QUERY: begin
                    res_we_o = 1'b1;
                    res_o    = W'(BUF_WORDS);
                end
                OP_OTPRD: begin
                    res_we_o = 1'b1;
                    res_o    = OTP_STUB;
                end
                OP_OTPWR: begin
                    if (st_q.otp_done) flt_o.aof = 1'b1;
                    else begin
                        st_d.otp_done = 1'b1;
                        st_d.busy = 1'b1; st_d.is_erase = 1'b0;
                        st_d.cnt  = CNT_W'(PROG_LAT);
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy_o       = st_q.busy;
    assign susp_o       = st_q.susp;
    assign susp_erase_o = st_q.is_erase;

    // R10: running and paused never overlap
    p_run_xor_pause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.busy && st_q.susp));

    // R4: a run always has cycles left on its timer
    p_timer_live_r4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |-> st_q.cnt != '0);

    // R6: protected launch never starts a run
    p_locked_stays_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_go && locked && (cmd == OP_WPROG || cmd == OP_ERASE || cmd == OP_BPROG))
        |=> !st_q.busy);

    // R11: launch during a run leaves the lock table alone
    p_busy_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (go && st_q.busy) |=> $stable(st_q.locks));

    // R10: resume while paused restarts the run next cycle
    p_resume_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (go && st_q.susp && cmd == OP_RESUME) |=> st_q.busy);
endmodule

// File: rtl/fcw_status.sv
module fcw_status
    import fcw_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         busy,
    input  logic         susp,
    input  logic         susp_erase,
    input  fault_t       flt,
    input  logic         rd_stat,
    output logic [W-1:0] stat_o
);
    logic [W-1:0] rc_d, rc_q, raise;

    always_comb begin
        raise               = '0;
        raise[SB_PROT]      = flt.prot;
        raise[SB_VLOW]      = flt.vlow;
        raise[SB_PERR]      = flt.perr;
        raise[SB_EERR]      = flt.eerr;
        raise[SB_AOF]       = flt.aof;
        raise[SB_RGN +: 2]  = flt.rgn;
        rc_d = (rd_stat ? (rc_q & ~CLR_MASK) : rc_q) | raise;

        stat_o            = rc_q;
        stat_o[SB_AVAIL]  = 1'b1;
        stat_o[SB_RDY]    = !busy;
        stat_o[SB_ESUSP]  = susp && susp_erase;
        stat_o[SB_PSUSP]  = susp && !susp_erase;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rc_q <= '0;
        else        rc_q <= rc_d & CLR_MASK;
    end

    // R7: a status read with no new fault leaves no sticky bit
    p_read_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stat && flt == '0) |=> (rc_q == '0));

    // R7: a fault on the clearing edge survives
    p_fault_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stat && flt.vlow) |=> rc_q[SB_VLOW]);

    // R7: sticky bits persist without a read
    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_stat && rc_q[SB_PROT]) |=> rc_q[SB_PROT]);
endmodule

// File: rtl/flash_cmd_window.sv
module flash_cmd_window
    import fcw_pkg::*;
#(
    parameter int AW         = 8,
    parameter int PROG_LAT   = 6,
    parameter int ERASE_LAT  = 10,
    parameter int NUM_BLOCKS = 8,
    parameter int BLK_LSB    = 16,
    parameter int BUF_WORDS  = 8,
    parameter logic [15:0] MFR_ID   = 16'h0089,
    parameter logic [15:0] DEV_ID   = 16'h88B0,
    parameter logic [15:0] BUF_LOC  = 16'h0100,
    parameter logic [15:0] OTP_STUB = 16'h5A5A,
    localparam int BLK_W  = $clog2(NUM_BLOCKS),
    localparam int FILL_W = $clog2(BUF_WORDS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [AW-1:0] addr,
    input  logic [15:0]   wdata,
    input  logic          vpp_low,
    output logic [15:0]   rdata,
    output logic          rd_valid
);
    logic [W-1:0]      cmd, data, alo, ahi, clo, chi, stat, res;
    logic [FILL_W-1:0] fill;
    logic              busy, susp, susp_erase, res_we, buf_use;
    logic              go, pause, rd_stat;
    logic [2*W-1:0]    full_adr;
    fault_t            flt;

    typedef struct packed {
        logic         vld;
        logic [W-1:0] dat;
    } rd_t;
    rd_t rd_d, rd_q;

    assign go       = wr_en && addr == AW'(OFS_GO)    && wdata == KEY_ONE;
    assign pause    = wr_en && addr == AW'(OFS_PAUSE) && wdata == KEY_ONE;
    assign rd_stat  = rd_en && addr == AW'(OFS_STAT);
    assign full_adr = {ahi, alo};

    fcw_params #(.AW(AW), .BUF_WORDS(BUF_WORDS)) u_prm (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .busy(busy), .res_we(res_we), .res(res), .buf_use(buf_use),
        .cmd_o(cmd), .data_o(data), .alo_o(alo), .ahi_o(ahi),
        .clo_o(clo), .chi_o(chi), .fill_o(fill)
    );

    fcw_engine #(
        .PROG_LAT(PROG_LAT), .ERASE_LAT(ERASE_LAT), .NUM_BLOCKS(NUM_BLOCKS),
        .BUF_WORDS(BUF_WORDS), .OTP_STUB(OTP_STUB)
    ) u_eng (
        .clk(clk), .rst_n(rst_n), .go(go), .pause(pause), .cmd(cmd),
        .blk(full_adr[BLK_LSB +: BLK_W]), .odd(full_adr[0]),
        .count({chi, clo}), .fill(fill), .vpp_low(vpp_low),
        .busy_o(busy), .susp_o(susp), .susp_erase_o(susp_erase), .flt_o(flt),
        .res_we_o(res_we), .res_o(res), .buf_use_o(buf_use)
    );

    fcw_status u_sts (
        .clk(clk), .rst_n(rst_n), .busy(busy), .susp(susp),
        .susp_erase(susp_erase), .flt(flt), .rd_stat(rd_stat), .stat_o(stat)
    );

    always_comb begin
        rd_d.vld = rd_en;
        rd_d.dat = rd_q.dat;
        if (rd_en) begin
            case (addr)
                AW'(OFS_Q0):     rd_d.dat = 16'h0050;
                AW'(OFS_Q1):     rd_d.dat = 16'h0046;
                AW'(OFS_Q2):     rd_d.dat = 16'h004F;
                AW'(OFS_Q3):     rd_d.dat = 16'h0057;
                AW'(OFS_MFR):    rd_d.dat = MFR_ID;
                AW'(OFS_DEV):    rd_d.dat = DEV_ID;
                AW'(OFS_BUFLOC): rd_d.dat = BUF_LOC;
                AW'(OFS_BUFSZ):  rd_d.dat = W'(BUF_WORDS);
                AW'(OFS_CMD):    rd_d.dat = cmd;
                AW'(OFS_DATA):   rd_d.dat = data;
                AW'(OFS_ALO):    rd_d.dat = alo;
                AW'(OFS_AHI):    rd_d.dat = ahi;
                AW'(OFS_CLO):    rd_d.dat = clo;
                AW'(OFS_CHI):    rd_d.dat = chi;
                AW'(OFS_STAT):   rd_d.dat = stat;
                default:         rd_d.dat = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rdata    = rd_q.dat;
    assign rd_valid = rd_q.vld;

    // R1: every read strobe yields valid data on the next cycle
    p_rd_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    // R3: a non-key write to the launch register starts nothing
    p_bad_key_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == AW'(OFS_GO) && wdata != KEY_ONE && !busy) |=> !busy);
endmodule

// File: tb/sim_flash_cmd_window.sv
module sim_flash_cmd_window;
    localparam int PL = 6;
    localparam int EL = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0, vpp_low = 1'b0;
    logic [7:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        rd_valid;

    int n_chk = 0, n_err = 0;
    logic [15:0] q_exp[$];
    logic [15:0] q_msk[$];
    string       q_tag[$];

    always #10 clk = ~clk;

    flash_cmd_window #(
        .AW(8), .PROG_LAT(PL), .ERASE_LAT(EL), .NUM_BLOCKS(8), .BLK_LSB(16),
        .BUF_WORDS(8), .MFR_ID(16'h0089), .DEV_ID(16'h88B0),
        .BUF_LOC(16'h0100), .OTP_STUB(16'h5A5A)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .vpp_low(vpp_low), .rdata(rdata), .rd_valid(rd_valid)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: compares read results against the scoreboard queue
    always @(negedge clk) begin
        if (rd_valid && q_exp.size() > 0) begin
            logic [15:0] e, m;
            string t;
            e = q_exp.pop_front();
            m = q_msk.pop_front();
            t = q_tag.pop_front();
            if (m != '0) chk((rdata & m) == (e & m), t, rdata, e);
        end
    end

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [15:0] e, input string t);
        q_exp.push_back(e); q_msk.push_back(16'hFFFF); q_tag.push_back(t);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic launch(input logic [15:0] c);
        wr(8'h80, c);
        wr(8'hC0, 16'h0001);
    endtask

    task automatic poll(output int nb, output logic [15:0] fin);
        nb = 0; fin = '0;
        for (int i = 0; i < 200; i++) begin
            q_exp.push_back('0); q_msk.push_back('0); q_tag.push_back("poll");
            rd_en = 1'b1; addr = 8'hCC;
            @(negedge clk);
            fin = rdata;
            if (fin[7]) break;
            nb++;
        end
        rd_en = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++; n_chk++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        int nb;
        logic [15:0] fin;
        idle(2);
        rst_n = 1'b1;
        idle(1);

        // R4 reset status, R1 fixed reads
        rd(8'hCC, 16'h8080, "R4 reset status");
        rd(8'h00, 16'h0050, "R1 query P");
        rd(8'h02, 16'h0046, "R1 query F");
        rd(8'h04, 16'h004F, "R1 query O");
        rd(8'h06, 16'h0057, "R1 query W");
        rd(8'h20, 16'h0089, "R1 mfr id");
        rd(8'h22, 16'h88B0, "R1 dev id");
        rd(8'h40, 16'h0100, "R1 buffer location");
        rd(8'h42, 16'h0008, "R1 buffer depth");

        // R2 split registers read back
        wr(8'h88, 16'h1234); wr(8'h8A, 16'h0003);
        wr(8'h90, 16'h0005); wr(8'h92, 16'h0000);
        rd(8'h88, 16'h1234, "R2 addr low");
        rd(8'h8A, 16'h0003, "R2 addr high");
        rd(8'h90, 16'h0005, "R2 count low");

        // R3 wrong launch key does nothing
        wr(8'h80, 16'h0041);
        wr(8'hC0, 16'h0002);
        rd(8'hCC, 16'h8080, "R3 key 2 ignored");

        // R4 word program latency
        launch(16'h0041);
        poll(nb, fin);
        chk(nb == PL, "R4 program busy cycles", nb, PL);
        chk(fin == 16'h8080, "R4 program done status", fin, 16'h8080);

        // R4 erase latency
        launch(16'h0020);
        poll(nb, fin);
        chk(nb == EL, "R4 erase busy cycles", nb, EL);

        // R5 lock and query, R6 protect, R7 clear
        launch(16'h0061);
        launch(16'h0065);
        rd(8'h84, 16'h0001, "R5 lock state set");
        launch(16'h0041);
        rd(8'hCC, 16'h8082, "R6 program on locked block");
        rd(8'hCC, 16'h8080, "R7 cleared after read");
        launch(16'h0020);
        rd(8'hCC, 16'h8082, "R6 erase on locked block");
        launch(16'h0062);
        launch(16'h0065);
        rd(8'h84, 16'h0000, "R5 lock state cleared");

        // R8 odd address
        wr(8'h88, 16'h1235);
        launch(16'h0041);
        rd(8'hCC, 16'h8380, "R8 odd address region code");
        rd(8'hCC, 16'h8080, "R7 region code cleared");
        wr(8'h88, 16'h1234);

        // R9 buffered program
        wr(8'hC4, 16'h0001);
        launch(16'h00E9);
        rd(8'hCC, 16'h8090, "R9 count above empty buffer");
        wr(8'h84, 16'hAAAA); wr(8'h84, 16'hBBBB); wr(8'h84, 16'hCCCC);
        wr(8'h90, 16'h0003);
        launch(16'h00E9);
        poll(nb, fin);
        chk(nb == PL && fin == 16'h8080, "R9 buffered program runs", nb, PL);
        wr(8'h90, 16'h0000);
        launch(16'h00E9);
        rd(8'hCC, 16'h8090, "R9 zero count");
        wr(8'h84, 16'h1111); wr(8'h84, 16'h2222);
        wr(8'hC4, 16'h0002);
        wr(8'h90, 16'h0002);
        launch(16'h00E9);
        poll(nb, fin);
        chk(nb == PL && fin == 16'h8080, "R9 clear key 2 ignored", nb, PL);
        wr(8'h84, 16'h3333);
        wr(8'hC4, 16'h0001);
        wr(8'h90, 16'h0001);
        launch(16'h00E9);
        rd(8'hCC, 16'h8090, "R9 buffer emptied by clear");

        // R12 low voltage at completion, R7 fault beats same-edge clear
        vpp_low = 1'b1;
        launch(16'h0041);
        poll(nb, fin);
        chk(fin == 16'h8088, "R7 R12 program fault kept over clear", fin, 16'h8088);
        launch(16'h0020);
        poll(nb, fin);
        chk(fin == 16'h80A8, "R12 erase low voltage", fin, 16'h80A8);
        vpp_low = 1'b0;
        rd(8'hCC, 16'h8080, "R7 cleared after fault read");

        // R10 pause and resume an erase
        launch(16'h0020);
        idle(3);
        wr(8'hC8, 16'h0001);
        rd(8'hCC, 16'h80C0, "R10 erase paused");
        launch(16'h0041);
        rd(8'hCC, 16'h80C0, "R10 other launch dropped while paused");
        launch(16'h00D0);
        poll(nb, fin);
        chk(nb == EL - 3, "R10 erase remaining cycles", nb, EL - 3);

        // R10 pause and resume a program
        launch(16'h0041);
        idle(1);
        wr(8'hC8, 16'h0001);
        rd(8'hCC, 16'h8084, "R10 program paused");
        launch(16'h00D0);
        poll(nb, fin);
        chk(nb == PL - 1, "R10 program remaining cycles", nb, PL - 1);

        // R11 resume with nothing paused
        launch(16'h00D0);
        rd(8'hCC, 16'h8080, "R11 stray resume");

        // R11 launch while busy, R2 write while busy
        wr(8'h88, 16'h0010); wr(8'h8A, 16'h0000);
        launch(16'h0020);
        wr(8'h88, 16'h7777);
        wr(8'hC0, 16'h0001);
        poll(nb, fin);
        chk(nb == EL - 2, "R11 launch while busy dropped", nb, EL - 2);
        chk(fin == 16'h8080, "R11 no fault from dropped launch", fin, 16'h8080);
        rd(8'h88, 16'h0010, "R2 write while busy ignored");

        // R13 one-time area and query
        launch(16'h0097);
        rd(8'h84, 16'h5A5A, "R13 otp read stub");
        launch(16'h0098);
        rd(8'h84, 16'h0008, "R13 info query depth");
        launch(16'h00C0);
        poll(nb, fin);
        chk(nb == PL, "R13 first otp program runs", nb, PL);
        launch(16'h00C0);
        rd(8'hCC, 16'h9080, "R13 second otp program faults");

        idle(4);
        chk(q_exp.size() == 0, "scoreboard drained", q_exp.size(), 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule